// File: doc/BRIEF.md
# Port-Selected ROM Bank Decoder

This block decodes the 16-bit address bus of an 8-bit processor into chip selects for a set of ROM banks, one 8k RAM and the IO space. A write to one IO port address loads a bank index from a field of the written byte; the decode that follows that write uses the new bank. Bank 0 is the primary bank: it answers reads across the whole upper half of memory (0x8000-0xFFFF), so while it is active the RAM at 0x8000-0x9FFF cannot be reached. Every other bank is a secondary bank of 24k that answers reads only at 0xA000-0xFFFF, which leaves the RAM window open.

For a ROM read the block also forms the physical ROM address: the bank index in the upper bits, and below it the distance of the address from the base of the selected bank's window. Writes never select a ROM. The bank count, the position of the select field, the port address and the window bases are parameters; a bank count that is not a power of two makes the register refuse indices that name no bank.

Top module: `rom_bank_decoder`

## Requirements
- R1: After reset the active bank is bank 0, so a read at 0x8000 asserts rom_cs bit 0 with rom_addr 0.
- R2: A write with wr=1 to address 0x0040 loads the active bank from port_wdata bits [SEL_LSB+BANK_W-1:SEL_LSB] (bits 4:3 with the defaults); the other bits of the byte have no effect, and the new bank is used from the next clock cycle on.
- R3: When NUM_BANKS is not a power of two, a port write whose field value is NUM_BANKS or above leaves the active bank unchanged; any cycle without a port write also leaves it unchanged.
- R4: With bank 0 active, a read in 0x8000-0xFFFF asserts rom_cs bit 0 and rom_addr = address - 0x8000, and ram_sel stays low for every address.
- R5: With secondary bank b active, a read in 0xA000-0xFFFF asserts rom_cs bit b and rom_addr = b*32768 + (address - 0xA000).
- R6: With a secondary bank active, a read or a write in 0x8000-0x9FFF asserts ram_sel and no rom_cs bit.
- R7: A write (wr=1) never asserts a rom_cs bit; a write that falls in the active bank's ROM window asserts no select at all.
- R8: An access (rd or wr) below 0x8000 asserts io_sel and never ram_sel or a rom_cs bit.
- R9: With rd=0 and wr=0 every select is low and rom_addr is 0.
- R10: At most one rom_cs bit is high at a time, and rom_addr is 0 whenever no rom_cs bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Processor address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| port_wdata | input | DATA_W | Write data, sampled for a port write |
| rom_cs | output | NUM_BANKS | One chip select per ROM bank |
| rom_addr | output | BANK_W+OFF_W | Physical ROM address: bank index above window offset |
| ram_sel | output | 1 | RAM select |
| io_sel | output | 1 | IO space select |

## Verification
On every cycle the assertions hold the selects mutually exclusive, keep ROM selects off during writes and below 0x8000, keep RAM hidden under bank 0, keep each bank's select inside its window, and tie the bank register to port writes alone. The exact physical ROM offset for each bank, the one-cycle delay before a new bank applies, the effect of junk bits beside the select field and the refusal of out-of-range indices in a five-bank build are shown only by the bench's scenarios against its reference model.

// File: rtl/rombank_pkg.sv
package rombank_pkg;

   // Coarse address class; which selects follow depends on the active bank.
   typedef enum logic [1:0] {
      CLS_NONE = 2'd0,
      CLS_IO   = 2'd1,
      CLS_RAM  = 2'd2,
      CLS_ROM  = 2'd3
   } addr_class_e;

   // Width of an offset inside a window that runs from base to the top of memory.
   function automatic int unsigned window_off_w(input int unsigned addr_w,
                                                input int unsigned base);
      int unsigned span;
      span = (32'd1 << addr_w) - base;
      return (span <= 1) ? 1 : $clog2(span);
   endfunction

endpackage

// File: rtl/rombank_select_reg.sv
module rombank_select_reg #(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned BANK_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BANK_W-1:0] field,
   output logic [BANK_W-1:0] bank
);

   logic accept;

   generate
      if (NUM_BANKS == (32'd1 << BANK_W)) begin : g_full
         // Every field value names a bank.
         assign accept = 1'b1;
      end else begin : g_partial
         assign accept = (field < BANK_W'(NUM_BANKS));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank <= '0;
      end else if (load && accept) begin
         bank <= field;
      end
   end

endmodule

// File: rtl/rombank_classify.sv
module rombank_classify
   import rombank_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned PRI_BASE = 32'h8000,
   parameter int unsigned RAM_BASE = 32'h8000,
   parameter int unsigned RAM_SIZE = 32'h2000
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              access,
   output addr_class_e       cls
);

   localparam logic [ADDR_W-1:0] PRI_LO = ADDR_W'(PRI_BASE);
   localparam logic [ADDR_W-1:0] RAM_LO = ADDR_W'(RAM_BASE);
   localparam logic [ADDR_W-1:0] RAM_HI = ADDR_W'(RAM_BASE + RAM_SIZE);

   always_comb begin
      if (!access) begin
         cls = CLS_NONE;
      end else if (addr < PRI_LO) begin
         cls = CLS_IO;
      end else if ((addr >= RAM_LO) && (addr < RAM_HI)) begin
         cls = CLS_RAM;
      end else begin
         cls = CLS_ROM;
      end
   end

endmodule

// File: rtl/rombank_window.sv
module rombank_window #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned BANK_W    = 2,
   parameter int unsigned OFF_W     = 15,
   parameter int unsigned PRI_BASE  = 32'h8000,
   parameter int unsigned SEC_BASE  = 32'hA000
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic [BANK_W-1:0]    bank,
   input  logic                 rd_only,
   output logic [NUM_BANKS-1:0] cs,
   output logic [OFF_W-1:0]     offset
);

   logic [OFF_W-1:0] off_arr [NUM_BANKS];

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         // Bank 0 owns the whole upper half; the rest start higher up.
         localparam int unsigned BASE = (b == 0) ? PRI_BASE : SEC_BASE;
         localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE);
         logic in_win;
         assign in_win     = (addr >= LO);
         assign cs[b]      = rd_only && in_win && (bank == BANK_W'(b));
         assign off_arr[b] = OFF_W'(addr - LO);
      end
   endgenerate

   always_comb begin
      offset = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (cs[b]) begin
            offset = offset | off_arr[b];
         end
      end
   end

endmodule

// File: rtl/rom_bank_decoder.sv
module rom_bank_decoder
   import rombank_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned SEL_LSB   = 3,
   parameter int unsigned PORT_ADDR = 32'h0040,
   parameter int unsigned PRI_BASE  = 32'h8000,
   parameter int unsigned SEC_BASE  = 32'hA000,
   parameter int unsigned RAM_BASE  = 32'h8000,
   parameter int unsigned RAM_SIZE  = 32'h2000,
   localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int unsigned OFF_W    = window_off_w(ADDR_W, PRI_BASE),
   localparam int unsigned PHYS_W   = BANK_W + OFF_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 rd,
   input  logic                 wr,
   input  logic [DATA_W-1:0]    port_wdata,
   output logic [NUM_BANKS-1:0] rom_cs,
   output logic [PHYS_W-1:0]    rom_addr,
   output logic                 ram_sel,
   output logic                 io_sel
);

   // Elaboration-time parameter checks.
   generate
      if (NUM_BANKS < 2 || NUM_BANKS > 8) begin : g_bad_banks
         $error("rom_bank_decoder: NUM_BANKS must lie in 2..8");
      end
      if (ADDR_W < 8 || ADDR_W > 24) begin : g_bad_addr_w
         $error("rom_bank_decoder: ADDR_W must lie in 8..24");
      end
      if (PRI_BASE == 0 || PRI_BASE >= (32'd1 << ADDR_W)) begin : g_bad_pri
         $error("rom_bank_decoder: PRI_BASE must fall inside the address space above 0");
      end
      if (SEC_BASE <= PRI_BASE || SEC_BASE >= (32'd1 << ADDR_W)) begin : g_bad_sec
         $error("rom_bank_decoder: SEC_BASE must sit above PRI_BASE");
      end
      if (RAM_BASE < PRI_BASE || RAM_BASE + RAM_SIZE > SEC_BASE || RAM_SIZE == 0) begin : g_bad_ram
         $error("rom_bank_decoder: RAM window must lie between PRI_BASE and SEC_BASE");
      end
      if (PORT_ADDR >= PRI_BASE) begin : g_bad_port
         $error("rom_bank_decoder: PORT_ADDR must lie in the IO space");
      end
      if (SEL_LSB + BANK_W > DATA_W) begin : g_bad_field
         $error("rom_bank_decoder: bank field does not fit in the port byte");
      end
   endgenerate

   logic              access;
   logic              rd_only;
   logic              port_load;
   logic [BANK_W-1:0] bank_q;
   logic [OFF_W-1:0]  win_off;
   addr_class_e       cls;
   logic              unused_wdata;

   assign access    = rd | wr;
   assign rd_only   = rd & ~wr;
   assign port_load = wr && (addr == ADDR_W'(PORT_ADDR));

   // Bits of the port byte outside the select field belong elsewhere.
   assign unused_wdata = ^port_wdata;

   rombank_select_reg #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W)
   ) u_sel (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (port_load),
      .field (port_wdata[SEL_LSB +: BANK_W]),
      .bank  (bank_q)
   );

   rombank_classify #(
      .ADDR_W   (ADDR_W),
      .PRI_BASE (PRI_BASE),
      .RAM_BASE (RAM_BASE),
      .RAM_SIZE (RAM_SIZE)
   ) u_cls (
      .addr   (addr),
      .access (access),
      .cls    (cls)
   );

   rombank_window #(
      .ADDR_W    (ADDR_W),
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W),
      .OFF_W     (OFF_W),
      .PRI_BASE  (PRI_BASE),
      .SEC_BASE  (SEC_BASE)
   ) u_win (
      .addr    (addr),
      .bank    (bank_q),
      .rd_only (rd_only),
      .cs      (rom_cs),
      .offset  (win_off)
   );

   always_comb begin
      rom_addr = (|rom_cs) ? {bank_q, win_off} : '0;
      // The RAM window shows through only under a secondary bank.
      ram_sel  = (cls == CLS_RAM) && (bank_q != '0);
      io_sel   = (cls == CLS_IO);
   end

endmodule

// File: rtl/rom_bank_decoder_chk.sv
module rom_bank_decoder_chk #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned BANK_W    = 2,
   parameter int unsigned PHYS_W    = 17,
   parameter int unsigned SEL_LSB   = 3,
   parameter int unsigned PORT_ADDR = 32'h0040,
   parameter int unsigned PRI_BASE  = 32'h8000,
   parameter int unsigned SEC_BASE  = 32'hA000,
   parameter int unsigned RAM_BASE  = 32'h8000,
   parameter int unsigned RAM_SIZE  = 32'h2000
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    addr,
   input logic                 rd,
   input logic                 wr,
   input logic [DATA_W-1:0]    port_wdata,
   input logic [NUM_BANKS-1:0] rom_cs,
   input logic [PHYS_W-1:0]    rom_addr,
   input logic                 ram_sel,
   input logic                 io_sel,
   input logic [BANK_W-1:0]    bank_q
);

   logic port_hit;
   logic field_ok;
   assign port_hit = wr && (addr == ADDR_W'(PORT_ADDR));
   assign field_ok = int'(port_wdata[SEL_LSB +: BANK_W]) < int'(NUM_BANKS);

   assert_bank_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (port_hit && field_ok) |=> (bank_q == $past(port_wdata[SEL_LSB +: BANK_W])));

   assert_bank_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(port_hit && field_ok) |=> $stable(bank_q));

   assert_primary_hides_ram_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_q == '0) |-> !ram_sel);

   assert_ram_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ram_sel |-> ((addr >= ADDR_W'(RAM_BASE)) && (addr < ADDR_W'(RAM_BASE + RAM_SIZE))
                   && (rom_cs == '0) && !io_sel));

   assert_no_rom_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr |-> (rom_cs == '0));

   assert_low_space_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (addr < ADDR_W'(PRI_BASE)) |-> ((rom_cs == '0) && !ram_sel));

   assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd || wr) |-> ((rom_cs == '0) && !ram_sel && !io_sel && (rom_addr == '0)));

   assert_onehot_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rom_cs));

   assert_zero_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_cs == '0) |-> (rom_addr == '0));

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_win
         localparam int unsigned BASE = (b == 0) ? PRI_BASE : SEC_BASE;
         assert_bank_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
            rom_cs[b] |-> ((addr >= ADDR_W'(BASE)) && (bank_q == BANK_W'(b)) && !io_sel));
      end
   endgenerate

endmodule

bind rom_bank_decoder rom_bank_decoder_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .NUM_BANKS (NUM_BANKS),
   .BANK_W    (BANK_W),
   .PHYS_W    (PHYS_W),
   .SEL_LSB   (SEL_LSB),
   .PORT_ADDR (PORT_ADDR),
   .PRI_BASE  (PRI_BASE),
   .SEC_BASE  (SEC_BASE),
   .RAM_BASE  (RAM_BASE),
   .RAM_SIZE  (RAM_SIZE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .addr       (addr),
   .rd         (rd),
   .wr         (wr),
   .port_wdata (port_wdata),
   .rom_cs     (rom_cs),
   .rom_addr   (rom_addr),
   .ram_sel    (ram_sel),
   .io_sel     (io_sel),
   .bank_q     (bank_q)
);

// File: tb/rom_bank_decoder_test.sv
module rom_bank_decoder_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [15:0] addr = '0;
   logic        rd = 1'b0;
   logic        wr = 1'b0;
   logic [7:0]  wdata = '0;

   logic [3:0]  cs4;
   logic [16:0] ra4;
   logic        rs4, io4;
   logic [4:0]  cs5;
   logic [17:0] ra5;
   logic        rs5, io5;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   rom_bank_decoder uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .port_wdata(wdata),
      .rom_cs(cs4), .rom_addr(ra4), .ram_sel(rs4), .io_sel(io4));

   rom_bank_decoder #(.NUM_BANKS(5)) uut_five (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .port_wdata(wdata),
      .rom_cs(cs5), .rom_addr(ra5), .ram_sel(rs5), .io_sel(io5));

   // Reference bank state for the four- and five-bank builds.
   int m4 = 0;
   int m5 = 0;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m4 = 0;
         m5 = 0;
      end else if (wr && addr == 16'h0040) begin
         m4 = (int'(wdata) >> 3) & 3;
         if (((int'(wdata) >> 3) & 7) < 5) m5 = (int'(wdata) >> 3) & 7;
      end
   end

   function automatic void model(input int bank, input int a, input bit r, input bit w,
                                 output int cs, output int ra, output bit rs, output bit io);
      cs = 0; ra = 0; rs = 0; io = 0;
      if (!(r || w)) return;
      if (a < 32'h8000) begin io = 1; return; end
      if (a < 32'hA000 && bank != 0) begin rs = 1; return; end
      if (r && !w) begin
         if (bank == 0) begin
            cs = 1; ra = a - 32'h8000;
         end else if (a >= 32'hA000) begin
            cs = 1 << bank; ra = bank * 32768 + (a - 32'hA000);
         end
      end
   endfunction

   function automatic string req_of(input int bank, input int a, input bit r, input bit w);
      if (!(r || w)) return "R9";
      if (a < 32'h8000) return "R8";
      if (w && (bank == 0 || a >= 32'hA000)) return "R7";
      if (a < 32'hA000 && bank != 0) return "R6";
      if (bank == 0) return "R4";
      return "R5";
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic compare_all();
      int cs, ra;
      bit rs, io;
      model(m4, int'(addr), rd, wr, cs, ra, rs, io);
      check(int'(cs4) == cs && int'(ra4) == ra && rs4 == rs && io4 == io,
            req_of(m4, int'(addr), rd, wr), "4-bank cs/addr",
            {int'(cs4), int'(rs4), int'(io4)} << 20 | int'(ra4),
            {cs, int'(rs), int'(io)} << 20 | ra);
      model(m5, int'(addr), rd, wr, cs, ra, rs, io);
      check(int'(cs5) == cs && int'(ra5) == ra && rs5 == rs && io5 == io,
            req_of(m5, int'(addr), rd, wr), "5-bank cs/addr",
            {int'(cs5), int'(rs5), int'(io5)} << 20 | int'(ra5),
            {cs, int'(rs), int'(io)} << 20 | ra);
      // R10: single select, zero address when nothing is selected
      check($onehot0(cs4) && (cs4 != 0 || ra4 == 0), "R10", "4-bank exclusivity",
            int'(cs4), cs);
   endtask

   task automatic cyc(input logic [15:0] a, input bit r, input bit w, input logic [7:0] d);
      @(posedge clk);
      #1;
      addr = a; rd = r; wr = w; wdata = d;
      @(negedge clk);
      compare_all();
   endtask

   task automatic set_bank(input logic [7:0] d);
      cyc(16'h0040, 1'b0, 1'b1, d);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int seed;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state selects the primary bank
      cyc(16'h8000, 1'b1, 1'b0, 8'h00);
      check(cs4 == 4'b0001 && ra4 == 0, "R1", "reset bank read at 0x8000",
            int'(cs4), 1);

      // R4: primary bank across its window, RAM hidden
      cyc(16'h9FFF, 1'b1, 1'b0, 8'h00);
      cyc(16'hA000, 1'b1, 1'b0, 8'h00);
      cyc(16'hFFFF, 1'b1, 1'b0, 8'h00);
      cyc(16'h8500, 1'b0, 1'b1, 8'h55);   // R7: write under primary
      // R8 / R9
      cyc(16'h1234, 1'b1, 1'b0, 8'h00);
      cyc(16'h7FFF, 1'b0, 1'b1, 8'hAA);
      cyc(16'hC000, 1'b0, 1'b0, 8'h00);

      // R2: field 2 with junk in the low bits
      set_bank(8'b0001_0101);
      cyc(16'hA000, 1'b1, 1'b0, 8'h00);
      check(cs4 == 4'b0100 && ra4 == 17'h10000, "R2", "bank 2 after port write",
            int'(ra4), 32'h10000);

      // R5 / R6 / R7 under a secondary bank
      cyc(16'hBEEF, 1'b1, 1'b0, 8'h00);
      cyc(16'h8000, 1'b1, 1'b0, 8'h00);
      cyc(16'h9FFF, 1'b0, 1'b1, 8'h12);
      cyc(16'hC000, 1'b0, 1'b1, 8'h34);
      cyc(16'hFFFF, 1'b1, 1'b0, 8'h00);

      // R2: walk every bank with differing junk bits
      for (int b = 0; b < 4; b++) begin
         set_bank(8'((b << 3) | 8'h07));
         cyc(16'hA123, 1'b1, 1'b0, 8'h00);
         cyc(16'h8123, 1'b1, 1'b0, 8'h00);
      end

      // R2: back-to-back writes, last one wins
      set_bank(8'h08);
      set_bank(8'h18);
      cyc(16'hA000, 1'b1, 1'b0, 8'h00);
      check(cs4 == 4'b1000, "R2", "second of two writes applies", int'(cs4), 8);

      // R3: five-bank build refuses indices 5..7
      set_bank(8'h20);
      cyc(16'hA000, 1'b1, 1'b0, 8'h00);
      check(cs5 == 5'b10000 && ra5 == 18'h20000, "R3", "five-bank index 4 accepted",
            int'(ra5), 32'h20000);
      set_bank(8'h30);
      cyc(16'hA010, 1'b1, 1'b0, 8'h00);
      check(cs5 == 5'b10000 && ra5 == 18'h20010, "R3", "five-bank index 6 ignored",
            int'(cs5), 16);
      set_bank(8'h38);
      cyc(16'hFFFF, 1'b1, 1'b0, 8'h00);
      // R3: writes to other IO addresses leave the bank alone
      cyc(16'h0041, 1'b0, 1'b1, 8'h00);
      cyc(16'hB000, 1'b1, 1'b0, 8'h00);
      check(cs5 == 5'b10000, "R3", "non-port write keeps bank", int'(cs5), 16);

      // Mixed sweep, including port writes and simultaneous strobes
      seed = 32'h1ACE;
      for (int i = 0; i < 400; i++) begin
         int s;
         seed = seed ^ (seed << 13);
         seed = seed ^ (seed >>> 17);
         seed = seed ^ (seed << 5);
         s = seed;
         if ((s & 15) == 0) set_bank(8'(s >> 8));
         else cyc(16'(s >> 12), 1'((s >> 4) & 1), 1'((s >> 5) & (s >> 6) & 1), 8'(s >> 20));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule